// File: doc/BRIEF.md
# Split-Transaction Bus Request Table

This block tracks the requests that are outstanding on a coherence bus whose address lines and data lines are separate. A cache puts a request on the address lines and releases the bus; the data arrives later on the response lines. Every cache holds an identical copy of this table. Each copy updates itself only from the traffic it observes on the bus, so all copies stay in step without any extra signalling.

When a request wins the bus, it carries a tag, and the table records the block address and the operation under the entry that the tag names. The response returns the same tag. When the table sees that response, it reports which block and which operation the response belongs to, and it frees the entry on the next clock edge.

Before a cache competes for the bus, it presents the block address of its next request to the probe port. The table answers in the same cycle. The answer is either a go-ahead together with the tag to use, which is the lowest free entry, or a stall. A stall is given in three cases: a request for that block is already outstanding, a request for that block is winning the bus in the same cycle, or no entry is free. The bus follows a two-stage pipeline, with request and snoop in the first stage and the response in the second.

Top module: `reqtab_top`

## Requirements
- R1: After reset every entry is free. A probe with no bus request in the same cycle is granted with tag 0.
- R2: A granted probe receives the lowest-numbered free entry as its tag. Tag value i names entry i.
- R3: A bus request with tag T records its block address in entry T at the clock edge. From the next cycle on, a probe for that block address stalls (lreq_ok=0, lreq_stall=1).
- R4: A response with tag T frees entry T at the clock edge. From the next cycle on, that entry can be granted again and its block address no longer blocks a probe.
- R5: When no entry is free, every probe stalls, whatever its address.
- R6: A bus request that is seen in the same cycle as a probe has two effects. If the request has the probe's block address, the probe stalls. In every case, the request's tag is excluded from the probe's choice of tag.
- R7: While rsp_valid is 1, rsp_addr and rsp_op show the block address and operation stored in entry rsp_tag. While rsp_valid is 0, both are 0.
- R8: A response does not release its entry within its own cycle. A probe for that entry's address in that cycle still stalls.
- R9: Operation codes are stored and returned unchanged: 2'b00 read, 2'b01 read-exclusive, 2'b10 upgrade.
- R10: In one cycle, a bus request into one entry and a response freeing a different entry both take effect.
- R11: While lreq_valid is 0, lreq_ok and lreq_stall are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lreq_valid | input | 1 | Local probe present |
| lreq_addr | input | BLK_W | Block address of the local probe |
| lreq_ok | output | 1 | Probe may go to arbitration |
| lreq_stall | output | 1 | Probe must wait |
| lreq_tag | output | TAG_W | Tag to use if the probe is granted |
| bus_req_valid | input | 1 | Request observed on the address lines |
| bus_req_addr | input | BLK_W | Block address of the observed request |
| bus_req_op | input | 2 | Operation of the observed request |
| bus_req_tag | input | TAG_W | Tag carried by the observed request |
| rsp_valid | input | 1 | Response observed on the data lines |
| rsp_tag | input | TAG_W | Tag carried by the response |
| rsp_addr | output | BLK_W | Block address stored under rsp_tag |
| rsp_op | output | 2 | Operation stored under rsp_tag |

## Verification
The properties assume that the bus behaves correctly. An observed request always carries the tag of an entry that is free in that cycle and that no response is freeing in that cycle. A response carries only the tag of an outstanding entry. The stimulus keeps to these rules. It issues each bus request under the lowest tag that the reference model of the bench holds free, and it sends responses only for entries that the model holds valid.

// File: rtl/reqtab_pkg.sv
package reqtab_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_READX = 2'b01,
        OP_UPGR  = 2'b10
    } op_e;
endpackage

// File: rtl/reqtab_store.sv
module reqtab_store #(
    parameter int ENTRIES = 8,
    parameter int BLK_W   = 26,
    localparam int TAG_W  = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            alloc_en,
    input  logic [TAG_W-1:0]                alloc_idx,
    input  logic [BLK_W-1:0]                alloc_addr,
    input  logic [1:0]                      alloc_op,
    input  logic                            free_en,
    input  logic [TAG_W-1:0]                free_idx,
    output logic [ENTRIES-1:0]              vld,
    output logic [ENTRIES-1:0][BLK_W-1:0]   addr_tab,
    output logic [ENTRIES-1:0][1:0]         op_tab
);
    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][BLK_W-1:0] addr;
        logic [ENTRIES-1:0][1:0]       op;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (free_en) begin
            st_d.vld[free_idx] = 1'b0;
        end
        if (alloc_en) begin
            st_d.vld[alloc_idx]  = 1'b1;
            st_d.addr[alloc_idx] = alloc_addr;
            st_d.op[alloc_idx]   = alloc_op;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld      = st_q.vld;
    assign addr_tab = st_q.addr;
    assign op_tab   = st_q.op;
endmodule

// File: rtl/reqtab_match.sv
module reqtab_match #(
    parameter int ENTRIES = 8,
    parameter int BLK_W   = 26
) (
    input  logic [ENTRIES-1:0]            vld,
    input  logic [ENTRIES-1:0][BLK_W-1:0] addr_tab,
    input  logic [BLK_W-1:0]              probe_addr,
    output logic                          hit_any
);
    logic [ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (addr_tab[g] == probe_addr);
    end

    assign hit_any = |hit_vec;
endmodule

// File: rtl/reqtab_alloc.sv
module reqtab_alloc #(
    parameter int ENTRIES = 8,
    localparam int TAG_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] avail,
    output logic [TAG_W-1:0]   pick_idx,
    output logic               pick_found
);
    always_comb begin
        pick_idx   = '0;
        pick_found = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (avail[i]) begin
                pick_idx   = i[TAG_W-1:0];
                pick_found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/reqtab_top.sv
module reqtab_top #(
    parameter int ENTRIES = 8,
    parameter int BLK_W   = 26,
    localparam int TAG_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lreq_valid,
    input  logic [BLK_W-1:0] lreq_addr,
    output logic             lreq_ok,
    output logic             lreq_stall,
    output logic [TAG_W-1:0] lreq_tag,
    input  logic             bus_req_valid,
    input  logic [BLK_W-1:0] bus_req_addr,
    input  logic [1:0]       bus_req_op,
    input  logic [TAG_W-1:0] bus_req_tag,
    input  logic             rsp_valid,
    input  logic [TAG_W-1:0] rsp_tag,
    output logic [BLK_W-1:0] rsp_addr,
    output logic [1:0]       rsp_op
);
    logic [ENTRIES-1:0]            vld;
    logic [ENTRIES-1:0][BLK_W-1:0] addr_tab;
    logic [ENTRIES-1:0][1:0]       op_tab;
    logic [ENTRIES-1:0]            bus_claim;
    logic [ENTRIES-1:0]            avail;
    logic [TAG_W-1:0]              pick_idx;
    logic                          pick_found;
    logic                          hit_any;
    logic                          collide;
    logic                          blocked;

    reqtab_store #(.ENTRIES(ENTRIES), .BLK_W(BLK_W)) store_i (
        .clk        (clk),
        .rst        (rst),
        .alloc_en   (bus_req_valid),
        .alloc_idx  (bus_req_tag),
        .alloc_addr (bus_req_addr),
        .alloc_op   (bus_req_op),
        .free_en    (rsp_valid),
        .free_idx   (rsp_tag),
        .vld        (vld),
        .addr_tab   (addr_tab),
        .op_tab     (op_tab)
    );

    reqtab_match #(.ENTRIES(ENTRIES), .BLK_W(BLK_W)) match_i (
        .vld        (vld),
        .addr_tab   (addr_tab),
        .probe_addr (lreq_addr),
        .hit_any    (hit_any)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_claim
        assign bus_claim[g] = bus_req_valid && (bus_req_tag == TAG_W'(g));
    end

    assign avail = ~vld & ~bus_claim;

    reqtab_alloc #(.ENTRIES(ENTRIES)) alloc_i (
        .avail      (avail),
        .pick_idx   (pick_idx),
        .pick_found (pick_found)
    );

    always_comb begin
        collide    = bus_req_valid && (bus_req_addr == lreq_addr);
        blocked    = hit_any || collide || !pick_found;
        lreq_ok    = lreq_valid && !blocked;
        lreq_stall = lreq_valid && blocked;
        lreq_tag   = pick_found ? pick_idx : '0;
        rsp_addr   = rsp_valid ? addr_tab[rsp_tag] : '0;
        rsp_op     = rsp_valid ? op_tab[rsp_tag] : 2'b00;
    end
endmodule

// File: rtl/reqtab_chk.sv
module reqtab_chk #(
    parameter int ENTRIES = 8,
    parameter int BLK_W   = 26,
    localparam int TAG_W  = $clog2(ENTRIES)
) (
    input logic             clk,
    input logic             rst,
    input logic             lreq_valid,
    input logic [BLK_W-1:0] lreq_addr,
    input logic             lreq_ok,
    input logic             lreq_stall,
    input logic [TAG_W-1:0] lreq_tag,
    input logic             bus_req_valid,
    input logic [BLK_W-1:0] bus_req_addr,
    input logic [TAG_W-1:0] bus_req_tag,
    input logic             rsp_valid,
    input logic [BLK_W-1:0] rsp_addr
);
    assert_reset_free_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && lreq_valid && !bus_req_valid) |-> (lreq_ok && lreq_tag == '0));

    assert_recorded_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |=> (!lreq_valid || lreq_addr != $past(bus_req_addr) || lreq_stall));

    assert_same_cycle_collide_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && lreq_valid && lreq_addr == bus_req_addr) |-> lreq_stall);

    assert_tag_not_claimed_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && lreq_ok) |-> (lreq_tag != bus_req_tag));

    assert_rsp_still_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && lreq_valid && lreq_addr == rsp_addr) |-> lreq_stall);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !lreq_valid |-> (!lreq_ok && !lreq_stall));
endmodule

bind reqtab_top reqtab_chk #(.ENTRIES(ENTRIES), .BLK_W(BLK_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .lreq_valid    (lreq_valid),
    .lreq_addr     (lreq_addr),
    .lreq_ok       (lreq_ok),
    .lreq_stall    (lreq_stall),
    .lreq_tag      (lreq_tag),
    .bus_req_valid (bus_req_valid),
    .bus_req_addr  (bus_req_addr),
    .bus_req_tag   (bus_req_tag),
    .rsp_valid     (rsp_valid),
    .rsp_addr      (rsp_addr)
);

// File: tb/reqtab_top_tb_top.sv
module reqtab_top_tb_top;
    localparam int E  = 8;
    localparam int AW = 26;
    localparam int TW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lreq_valid = 1'b0;
    logic [AW-1:0] lreq_addr = '0;
    logic          lreq_ok, lreq_stall;
    logic [TW-1:0] lreq_tag;
    logic          bus_req_valid = 1'b0;
    logic [AW-1:0] bus_req_addr = '0;
    logic [1:0]    bus_req_op = 2'b00;
    logic [TW-1:0] bus_req_tag = '0;
    logic          rsp_valid = 1'b0;
    logic [TW-1:0] rsp_tag = '0;
    logic [AW-1:0] rsp_addr;
    logic [1:0]    rsp_op;

    always #10 clk = ~clk;

    reqtab_top #(.ENTRIES(E), .BLK_W(AW)) dut_i (
        .clk(clk), .rst(rst),
        .lreq_valid(lreq_valid), .lreq_addr(lreq_addr),
        .lreq_ok(lreq_ok), .lreq_stall(lreq_stall), .lreq_tag(lreq_tag),
        .bus_req_valid(bus_req_valid), .bus_req_addr(bus_req_addr),
        .bus_req_op(bus_req_op), .bus_req_tag(bus_req_tag),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
        .rsp_addr(rsp_addr), .rsp_op(rsp_op)
    );

    typedef struct {
        string         rq;
        bit            ok;
        bit            stall;
        bit            chk_tag;
        logic [TW-1:0] tag;
        bit            chk_rsp;
        logic [AW-1:0] raddr;
        logic [1:0]    rop;
    } exp_t;

    exp_t   exp_q[$];
    event   sample_ev;
    int     checks = 0;
    int     errors = 0;
    bit     done = 1'b0;

    bit            mv[E];
    logic [AW-1:0] ma[E];
    logic [1:0]    mo[E];

    task automatic compare(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    initial begin : monitor
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                compare(it.rq, "lreq_ok", 32'(lreq_ok), 32'(it.ok));
                compare(it.rq, "lreq_stall", 32'(lreq_stall), 32'(it.stall));
                if (it.chk_tag) compare(it.rq, "lreq_tag", 32'(lreq_tag), 32'(it.tag));
                if (it.chk_rsp) begin
                    compare(it.rq, "rsp_addr", 32'(rsp_addr), 32'(it.raddr));
                    compare(it.rq, "rsp_op", 32'(rsp_op), 32'(it.rop));
                end
            end
        end
    end

    function automatic int lowest_free(input int skip);
        for (int i = 0; i < E; i++) begin
            if (!mv[i] && i != skip) return i;
        end
        return -1;
    endfunction

    // One bus cycle: drive, predict, sample, then advance the model.
    task automatic step(input bit lv, input logic [AW-1:0] la,
                        input bit bv, input logic [AW-1:0] ba, input logic [1:0] bo,
                        input bit rv, input int rt, input string rq);
        exp_t e;
        int   bt;
        int   pick;
        bit   match;
        @(negedge clk);
        bt = bv ? lowest_free(-1) : -1;
        lreq_valid    = lv;
        lreq_addr     = la;
        bus_req_valid = bv;
        bus_req_addr  = ba;
        bus_req_op    = bo;
        bus_req_tag   = (bt < 0) ? '0 : TW'(bt);
        rsp_valid     = rv;
        rsp_tag       = TW'(rt);
        #5;
        match = bv && (ba == la);
        for (int i = 0; i < E; i++) if (mv[i] && ma[i] == la) match = 1'b1;
        pick = lowest_free(bt);
        e.rq      = rq;
        e.ok      = lv && !match && (pick >= 0);
        e.stall   = lv && (match || pick < 0);
        e.chk_tag = e.ok;
        e.tag     = (pick < 0) ? '0 : TW'(pick);
        e.chk_rsp = 1'b1;
        e.raddr   = rv ? ma[rt] : '0;
        e.rop     = rv ? mo[rt] : 2'b00;
        exp_q.push_back(e);
        ->sample_ev;
        @(posedge clk);
        if (rv) mv[rt] = 1'b0;
        if (bv) begin
            mv[bt] = 1'b1;
            ma[bt] = ba;
            mo[bt] = bo;
        end
    endtask

    initial begin : watchdog
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        for (int i = 0; i < E; i++) begin
            mv[i] = 1'b0;
            ma[i] = '0;
            mo[i] = 2'b00;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: empty table grants tag 0; R11: idle probe is quiet
        step(1, 26'h10, 0, 0, 2'b00, 0, 0, "R1");
        step(0, 26'h10, 0, 0, 2'b00, 0, 0, "R11");
        // R6: bus takes entry 0, probe to another block gets tag 1
        step(1, 26'h200, 1, 26'h100, 2'b00, 0, 0, "R6");
        // R3: recorded block now blocks
        step(1, 26'h100, 0, 0, 2'b00, 0, 0, "R3");
        // R2: fill the table, probing other blocks each cycle
        for (int k = 1; k < E; k++) begin
            step(1, 26'h3ff, 1, AW'(26'h100 + k), 2'(k % 3), 0, 0, "R2");
        end
        // R5: full table stalls any address
        step(1, 26'h2aa, 0, 0, 2'b00, 0, 0, "R5");
        // R7, R9, R8: response for entry 4 (read-exclusive) reports and still blocks
        step(1, 26'h104, 0, 0, 2'b00, 1, 4, "R7 R9 R8");
        // R4: entry 4 is free again and its address no longer blocks
        step(1, 26'h104, 0, 0, 2'b00, 0, 0, "R4");
        step(1, 26'h555, 0, 0, 2'b00, 0, 0, "R4");
        // R10: allocate entry 4 while entry 5 frees
        step(1, 26'h666, 1, 26'h300, 2'b10, 1, 5, "R10");
        step(1, 26'h105, 0, 0, 2'b00, 0, 0, "R10");
        step(1, 26'h300, 0, 0, 2'b00, 1, 4, "R10 R9");
        // R6: same-cycle request for the probed block stalls
        step(1, 26'h777, 1, 26'h777, 2'b01, 0, 0, "R6");
        step(1, 26'h777, 0, 0, 2'b00, 1, 0, "R3 R7");
        step(1, 26'h100, 0, 0, 2'b00, 0, 0, "R4");

        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule